// File: doc/BRIEF.md
# Single-Command Handoff Register Block

This block sits between a host register bus and an internal command executor. The host first loads a parameter word into the extension register. It then writes the command register, and that write is the trigger. When the block is idle, the trigger captures the low 31 bits of the write data as the command. It then raises a busy flag on its own and sends a one-cycle launch pulse to the executor. The pulse carries the stored command and the extension value.

Only one command can be in flight at a time. While busy is high, the block discards every host write to either register without a trace, so the in-flight command and its parameter stay unchanged until the executor reports completion with a one-cycle done strobe. A read of the command register returns the busy flag in bit 31 above the stored command bits. The executor never sees a half-updated parameter, and the host can poll for completion with ordinary reads.

Top module: `cmd_handoff`

## Requirements
- R1: After reset, busy, cmdValid, cmdOut, extOut and both register read values are all zero.
- R2: A write to the command address (word 0) while busy is low stores wrData[30:0] as the command and sets busy in the next cycle. Bit 31 of the write data has no effect.
- R3: cmdValid is high for exactly the one cycle that follows an accepted command write, and it is never high at any other time.
- R4: A write to the command address while busy is high is dropped. The stored command stays the same and no cmdValid pulse follows.
- R5: A write to the extension address (word 1) while busy is low stores all 32 data bits. The same write while busy is high is dropped.
- R6: execDone while busy clears busy in the next cycle. execDone while idle has no effect.
- R7: If execDone and a register write arrive in the same cycle while busy is high, busy clears and the write is still dropped.
- R8: cmdOut and extOut hold their values for as long as busy stays high after a launch.
- R9: Reading the command address returns {busy, command}, and reading the extension address returns the extension value. Reading any other address returns zero.
- R10: Writes to unmapped addresses (words 2 and 3) change neither register nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Host write strobe |
| addr | input | 2 | Host word address (0 = command, 1 = extension) |
| wrData | input | 32 | Host write data |
| rdData | output | 32 | Combinational read data for addr |
| cmdValid | output | 1 | One-cycle launch pulse to the executor |
| cmdOut | output | 31 | Stored command and parameter bits |
| extOut | output | 32 | Stored extension parameter |
| busy | output | 1 | Command in flight |
| execDone | input | 1 | Executor completion strobe |

## Verification
Directed sequences cover four cases: a launch from idle, a burst of writes to both registers while busy, done arriving together with a write, and done while idle. These separate a block that queues or overwrites from one that truly drops. A long stream of random writes to all four addresses, mixed with random done strobes, is checked each cycle against a bench model. This catches an off-by-one in when busy rises or falls, a stray or doubled launch pulse, and a wrong read mux. Write data with bit 31 set shows that the host cannot force the flag.

// File: rtl/cmd_handoff_pkg.sv
package cmd_handoff_pkg;

  typedef struct packed {
    logic loadCmd;
    logic loadExt;
  } strobe_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CMD  = 2'd1,
    TGT_EXT  = 2'd2
  } target_t;

endpackage

// File: rtl/cmd_handoff_ctrl.sv
module cmd_handoff_ctrl
  import cmd_handoff_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CMD_ADDR = 0,
  parameter int EXT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              execDone,
  output strobe_t           strobes,
  output target_t           rdSel,
  output logic              busy,
  output logic              cmdValid
);

  localparam logic [ADDR_W-1:0] CmdWord = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] ExtWord = ADDR_W'(EXT_ADDR);

  target_t target;
  logic    accept;

  always_comb begin
    if (addr == CmdWord)      target = TGT_CMD;
    else if (addr == ExtWord) target = TGT_EXT;
    else                      target = TGT_NONE;
  end

  assign rdSel  = target;
  assign accept = wrEn && !busy && (target == TGT_CMD);

  always_comb begin
    strobes         = '0;
    strobes.loadCmd = accept;
    strobes.loadExt = wrEn && !busy && (target == TGT_EXT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cmdValid <= 1'b0;
    end else begin
      cmdValid <= accept;
      if (accept)
        busy <= 1'b1;
      else if (execDone)
        busy <= 1'b0;
    end
  end

endmodule

// File: rtl/cmd_handoff_dp.sv
module cmd_handoff_dp
  import cmd_handoff_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  target_t           rdSel,
  input  logic              busy,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-2:0] cmdOut,
  output logic [DATA_W-1:0] extOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int CMD_W = DATA_W - 1;

  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] extReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      extReg <= '0;
    end else begin
      if (strobes.loadCmd) cmdReg <= wrData[CMD_W-1:0];
      if (strobes.loadExt) extReg <= wrData;
    end
  end

  always_comb begin
    unique case (rdSel)
      TGT_CMD: rdData = {busy, cmdReg};
      TGT_EXT: rdData = extReg;
      default: rdData = '0;
    endcase
  end

  assign cmdOut = cmdReg;
  assign extOut = extReg;

endmodule

// File: rtl/cmd_handoff.sv
module cmd_handoff
  import cmd_handoff_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int CMD_ADDR = 0,
  parameter int EXT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              cmdValid,
  output logic [DATA_W-2:0] cmdOut,
  output logic [DATA_W-1:0] extOut,
  output logic              busy,
  input  logic              execDone
);

  strobe_t strobes;
  target_t rdSel;

  cmd_handoff_ctrl #(
    .ADDR_W  (ADDR_W),
    .CMD_ADDR(CMD_ADDR),
    .EXT_ADDR(EXT_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .execDone(execDone),
    .strobes (strobes),
    .rdSel   (rdSel),
    .busy    (busy),
    .cmdValid(cmdValid)
  );

  cmd_handoff_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .rdSel  (rdSel),
    .busy   (busy),
    .wrData (wrData),
    .cmdOut (cmdOut),
    .extOut (extOut),
    .rdData (rdData)
  );

endmodule

// File: rtl/cmd_handoff_chk.sv
module cmd_handoff_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int CMD_ADDR = 0,
  parameter int EXT_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              cmdValid,
  input logic [DATA_W-2:0] cmdOut,
  input logic [DATA_W-1:0] extOut,
  input logic              busy,
  input logic              execDone
);

  logic cmdHit;
  logic extHit;
  assign cmdHit = (addr == ADDR_W'(CMD_ADDR));
  assign extHit = (addr == ADDR_W'(EXT_ADDR));

  AST_ACCEPT_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdHit && !busy) |=> (busy && cmdValid)); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R3

  AST_PULSE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy); // R3

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && cmdHit) |=> (!cmdValid && $stable(cmdOut))); // R4

  AST_EXT_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && extHit) |=> $stable(extOut)); // R5

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && execDone) |=> !busy); // R6

  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && execDone && wrEn) |=> (!busy && !cmdValid)); // R7

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cmdValid) |-> ($stable(cmdOut) && $stable(extOut))); // R8

  AST_READ_BUSY_BIT: assert property (@(posedge clk) disable iff (!rstN)
    cmdHit |-> (rdData == {busy, cmdOut})); // R9

endmodule

bind cmd_handoff cmd_handoff_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .CMD_ADDR(CMD_ADDR),
  .EXT_ADDR(EXT_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .rdData  (rdData),
  .cmdValid(cmdValid),
  .cmdOut  (cmdOut),
  .extOut  (extOut),
  .busy    (busy),
  .execDone(execDone)
);

// File: tb/tb_cmd_handoff.sv
module tb_cmd_handoff;

  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          cmdValid;
  logic [DW-2:0] cmdOut;
  logic [DW-1:0] extOut;
  logic          busy;
  logic          execDone = 1'b0;

  int checks = 0;
  int fails  = 0;

  // bench model state
  bit          mBusy  = 1'b0;
  bit          mValid = 1'b0;
  bit [DW-2:0] mCmd   = '0;
  bit [DW-1:0] mExt   = '0;

  always #10 clk = ~clk; // 50 MHz

  cmd_handoff dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cmdValid(cmdValid), .cmdOut(cmdOut), .extOut(extOut),
    .busy(busy), .execDone(execDone)
  );

  function automatic bit [DW-1:0] expRead(input bit [AW-1:0] a);
    if (a == 2'd0)      return {mBusy, mCmd};
    else if (a == 2'd1) return mExt;
    else                return '0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare all outputs against the model
  task automatic checkAll(input string req);
    chk(busy === mBusy, {req, " busy"}, 32'(busy), 32'(mBusy));
    chk(cmdValid === mValid, {req, " cmdValid"}, 32'(cmdValid), 32'(mValid));
    chk(cmdOut === mCmd, {req, " cmdOut"}, 32'(cmdOut), 32'(mCmd));
    chk(extOut === mExt, {req, " extOut"}, extOut, mExt);
    chk(rdData === expRead(addr), {req, " rdData"}, rdData, expRead(addr));
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit w, input bit [AW-1:0] a, input bit [DW-1:0] d,
                      input bit dn, input string req);
    bit acc;
    bit ldExt;
    wrEn = w; addr = a; wrData = d; execDone = dn;
    @(posedge clk);
    acc   = w && (a == 2'd0) && !mBusy;
    ldExt = w && (a == 2'd1) && !mBusy;
    mValid = acc;
    if (acc) mCmd = d[DW-2:0];
    if (ldExt) mExt = d;
    if (acc) mBusy = 1'b1;
    else if (dn) mBusy = 1'b0;
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4471));
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      addr = AW'(a);
      #1;
      chk(rdData === '0, "R1 reset read", rdData, '0);
    end
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R10: unmapped writes
    step(1, 2'd2, 32'hFFFF_FFFF, 0, "R10");
    step(1, 2'd3, 32'hA5A5_A5A5, 0, "R10");
    // R6: done while idle
    step(0, 2'd0, 0, 1, "R6 idle done");
    // R5: ext load idle, then R2 launch with bit31 set
    step(1, 2'd1, 32'hDEAD_BEEF, 0, "R5");
    step(1, 2'd0, 32'hFFFF_0123, 0, "R2 R3 launch");
    chk(cmdValid === 1'b1, "R3 pulse", 32'(cmdValid), 32'd1);
    chk(rdData[31] === 1'b1, "R9 busy bit", 32'(rdData[31]), 32'd1);
    // R4/R5/R8: writes while busy dropped
    step(1, 2'd0, 32'h1234_5678, 0, "R4");
    chk(cmdValid === 1'b0, "R3 pulse ends", 32'(cmdValid), 32'd0);
    step(1, 2'd1, 32'h0BAD_F00D, 0, "R5 busy");
    step(0, 2'd1, 0, 0, "R8");
    chk(extOut === 32'hDEAD_BEEF, "R8 ext held", extOut, 32'hDEAD_BEEF);
    chk(cmdOut === 31'h7FFF_0123, "R2 bit31 ignored", 32'(cmdOut), 32'h7FFF_0123);
    // R7: done together with command write
    step(1, 2'd0, 32'h0000_0077, 1, "R7");
    chk(busy === 1'b0 && cmdValid === 1'b0, "R7 dropped", 32'(busy), 32'd0);
    chk(cmdOut === 31'h7FFF_0123, "R7 cmd kept", 32'(cmdOut), 32'h7FFF_0123);
    // R6: relaunch then done clears
    step(1, 2'd0, 32'h0000_0042, 0, "R2");
    step(0, 2'd0, 0, 1, "R6");
    chk(busy === 1'b0, "R6 cleared", 32'(busy), 32'd0);
    // R9: unmapped read
    step(0, 2'd3, 0, 0, "R9");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit w  = ($urandom % 2) == 0;
      bit [AW-1:0] a = AW'($urandom % 4);
      bit [DW-1:0] d = $urandom;
      bit dn = mBusy ? (($urandom % 4) == 0) : (($urandom % 8) == 0);
      step(w, a, d, dn, "R2 R4 R5 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule